// File: doc/BRIEF.md
# Warm Reset Sequencer

This block runs the chip-level warm reset. A warm reset can come from any of several internal request lines or from outside the chip through a shared active-low open-drain reset pin. Whatever the source, the block makes functional IO pads go high-impedance at once. It holds the host processor and the plain peripherals in reset. It then works through a timed sequence. One step asks the memory controller to empty its queue and put DRAM into self-refresh. Another step pulls the shared pin low. A final hold phase comes last. The host processor and the plain peripherals then leave reset without help. Subsystems that carry their own CPU stay in reset until software frees each one with a write strobe.

There are two source orders. For an internal source the order is drain, then pin drive for the programmed first duration, then hold for the programmed second duration. For a pin source the block echoes the low level on the pin for a fixed 30 cycles from detection, then drains, then holds. The pin is sampled through a two-stage synchronizer. The block's own drive, and its echo through the synchronizer, never counts as a new pin request. A new request in the middle of a sequence restarts it. Clocks keep running throughout. A power-on reset input overrides everything.

Top module: `wrst_seq_top`

## Requirements
- R1: While `por_rst` is high, `host_rst`, `periph_rst`, `io_tristate`, `rst_out` and every `lcpu_rst` bit are 1, and `pin_drv_low` and `drain_req` are 0. After it falls with no request pending, the host-side resets drop while `lcpu_rst` stays all ones.
- R2: A cycle in which any `warm_req` bit is 1 starts a sequence. From the next cycle on, `io_tristate`, `host_rst`, `periph_rst` and `drain_req` are 1 and `pin_drv_low` is 0. `dbg_io_oe` stays 1 throughout.
- R3: The drain step ends on the cycle in which `drain_ack` is sampled high. `drain_req` is high for exactly as many cycles as it took the acknowledge to arrive.
- R4: Without an acknowledge, the drain step ends after exactly 50 cycles of `drain_req`.
- R5: For an internal source, `pin_drv_low` is high for N1 cycles right after the drain. N1 = `rst_time_cfg[7:0]`, and a value of 0 counts as 1.
- R6: After the pin phase of an internal source, a hold of N2 cycles follows, with N2 = `rst_time_cfg[12:8]` and 0 counting as 1. Then `host_rst` and `periph_rst` fall. An internal sequence keeps `host_rst` high for drain + N1 + N2 cycles.
- R7: A low on `pin_in` that the block is not driving shows up as `host_rst` high 3 clock edges after the low first appears. The block then drives `pin_drv_low` for exactly 30 cycles, then drains, then holds N2 cycles.
- R8: Releasing its own pin drive never starts a further sequence, and no sequence runs without a request.
- R9: A new request during a sequence restarts it at the drain step. `host_rst` stays high across the restart.
- R10: Local CPU resets are set by any sequence and stay set after it. Bit i clears only on a pulse of `lcpu_rel_wr[i]` while no sequence is running; a pulse during a sequence leaves the bit set.
- R11: Raising `por_rst` during a sequence removes pin drive and the drain request on the next cycle and abandons the sequence.
- R12: `tst_rst` never asserts `rst_out`. It alone drives `dbg_io_oe` to 0.
- R13: `rst_out`, `periph_rst` and `io_tristate` equal `host_rst` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| tst_rst | input | 1 | Test-logic reset, active high |
| warm_req | input | N_SRC | Internal warm reset requests, any bit high requests |
| pin_in | input | 1 | Level seen at the shared reset pad, active low |
| pin_drv_low | output | 1 | 1 pulls the shared pad low (open drain) |
| drain_ack | input | 1 | Memory controller reports queue empty and self-refresh entered |
| drain_req | output | 1 | Request to memory controller to drain and enter self-refresh |
| rst_time_cfg | input | 13 | [7:0] pin phase length, [12:8] hold phase length |
| lcpu_rel_wr | input | N_LCPU | Software release strobe per local-CPU subsystem |
| io_tristate | output | 1 | 1 forces functional IO pads to high impedance |
| host_rst | output | 1 | Host processor reset |
| periph_rst | output | 1 | Reset for peripherals without a local CPU |
| lcpu_rst | output | N_LCPU | Local reset per CPU-bearing subsystem |
| rst_out | output | 1 | Reset-out status, high while host reset is held |
| dbg_io_oe | output | 1 | Enable for test and debug IOs, unaffected by warm reset |

## Verification
The properties rely on some assumptions about the surroundings. `drain_ack` is raised only while `drain_req` is high. No warm request coincides with `por_rst`. An outside agent that pulls the pin lets go before the block's own 30-cycle drive ends. `rst_time_cfg` stays still while a sequence runs. The stimulus follows all of these. An acknowledge responder answers only a live drain request, after a chosen delay or never. Each request pulse and each power-on reset comes at a distinct point of the sequence. The pad is modelled as the wired-AND of the block's drive and a switch that opens after about ten cycles. The duration fields change only while the block is idle.

// File: rtl/wrst_pkg.sv
package wrst_pkg;

    localparam int T1_W   = 8;
    localparam int T2_W   = 5;
    localparam int TIME_W = T1_W + T2_W;
    localparam int CNT_W  = T1_W;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DRAIN,
        SEQ_PIN,
        SEQ_HOLD
    } seq_state_e;

    // Field order follows the register: hold length on top, pin length below.
    typedef struct packed {
        logic [T2_W-1:0] hold_len;
        logic [T1_W-1:0] pin_len;
    } rst_time_t;

    typedef struct packed {
        logic busy;
        logic drain;
        logic drive;
    } seq_ctl_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/wrst_pin_sync.sv
module wrst_pin_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic drv_low,
    output logic ext_low
);

    logic [SYNC_N-1:0] sync_q;
    logic [SYNC_N-1:0] drv_hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '1;
            drv_hist_q <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_N-2:0], pin_in};
            drv_hist_q <= {drv_hist_q[SYNC_N-2:0], drv_low};
        end
    end

    // A low that still echoes our own drive through the flops is masked.
    assign ext_low = ~sync_q[SYNC_N-1] & ~drv_low & ~(|drv_hist_q);

endmodule

// File: rtl/wrst_seq_fsm.sv
module wrst_seq_fsm
    import wrst_pkg::*;
#(
    parameter int DRAIN_MAX = 50,
    parameter int EXT_DRV   = 30
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_int,
    input  logic      start_ext,
    input  logic      drain_ack,
    input  rst_time_t times,
    output seq_ctl_t  ctl
);

    localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(DRAIN_MAX - 1);
    localparam logic [CNT_W-1:0] EXT_LAST   = CNT_W'(EXT_DRV - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ext_q;
    logic [CNT_W-1:0] pin_last;
    logic [CNT_W-1:0] hold_last;
    logic             phase_end;

    always_comb begin
        pin_last  = ext_q ? EXT_LAST : at_least_one(times.pin_len) - CNT_W'(1);
        hold_last = at_least_one(CNT_W'(times.hold_len)) - CNT_W'(1);
        case (state_q)
            SEQ_DRAIN: phase_end = drain_ack || (cnt_q >= DRAIN_LAST);
            SEQ_PIN:   phase_end = cnt_q >= pin_last;
            SEQ_HOLD:  phase_end = cnt_q >= hold_last;
            default:   phase_end = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            ext_q   <= 1'b0;
        end else if (start_int) begin
            state_q <= SEQ_DRAIN;
            cnt_q   <= '0;
            ext_q   <= 1'b0;
        end else if (start_ext) begin
            state_q <= SEQ_PIN;
            cnt_q   <= '0;
            ext_q   <= 1'b1;
        end else if (phase_end) begin
            cnt_q <= '0;
            case (state_q)
                SEQ_DRAIN: state_q <= ext_q ? SEQ_HOLD : SEQ_PIN;
                SEQ_PIN:   state_q <= ext_q ? SEQ_DRAIN : SEQ_HOLD;
                default:   state_q <= SEQ_IDLE;
            endcase
        end else if (state_q != SEQ_IDLE) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        ctl.busy  = state_q != SEQ_IDLE;
        ctl.drain = state_q == SEQ_DRAIN;
        ctl.drive = state_q == SEQ_PIN;
    end

endmodule

// File: rtl/wrst_lcpu_bank.sv
module wrst_lcpu_bank #(
    parameter int N_LCPU = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [N_LCPU-1:0] rel_wr,
    output logic [N_LCPU-1:0] hold
);

    for (genvar i = 0; i < N_LCPU; i++) begin : g_sub
        logic hold_q;
        always_ff @(posedge clk) begin
            if (rst || busy) begin
                hold_q <= 1'b1;
            end else if (rel_wr[i]) begin
                hold_q <= 1'b0;
            end
        end
        assign hold[i] = hold_q;
    end

endmodule

// File: rtl/wrst_seq_top.sv
module wrst_seq_top
    import wrst_pkg::*;
#(
    parameter int N_SRC     = 4,
    parameter int N_LCPU    = 3,
    parameter int DRAIN_MAX = 50,
    parameter int EXT_DRV   = 30,
    parameter int SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              tst_rst,
    input  logic [N_SRC-1:0]  warm_req,
    input  logic              pin_in,
    output logic              pin_drv_low,
    input  logic              drain_ack,
    output logic              drain_req,
    input  logic [TIME_W-1:0] rst_time_cfg,
    input  logic [N_LCPU-1:0] lcpu_rel_wr,
    output logic              io_tristate,
    output logic              host_rst,
    output logic              periph_rst,
    output logic [N_LCPU-1:0] lcpu_rst,
    output logic              rst_out,
    output logic              dbg_io_oe
);

    rst_time_t times;
    seq_ctl_t  ctl;
    logic      ext_low;
    logic      any_req;

    assign times   = rst_time_t'(rst_time_cfg);
    assign any_req = |warm_req;

    wrst_pin_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk     (clk),
        .rst     (por_rst),
        .pin_in  (pin_in),
        .drv_low (ctl.drive),
        .ext_low (ext_low)
    );

    wrst_seq_fsm #(.DRAIN_MAX(DRAIN_MAX), .EXT_DRV(EXT_DRV)) u_fsm (
        .clk       (clk),
        .rst       (por_rst),
        .start_int (any_req),
        .start_ext (ext_low),
        .drain_ack (drain_ack),
        .times     (times),
        .ctl       (ctl)
    );

    wrst_lcpu_bank #(.N_LCPU(N_LCPU)) u_lcpu (
        .clk    (clk),
        .rst    (por_rst),
        .busy   (ctl.busy),
        .rel_wr (lcpu_rel_wr),
        .hold   (lcpu_rst)
    );

    assign pin_drv_low = ctl.drive;
    assign drain_req   = ctl.drain;
    assign host_rst    = por_rst | ctl.busy;
    assign periph_rst  = host_rst;
    assign io_tristate = host_rst;
    assign rst_out     = host_rst;
    assign dbg_io_oe   = ~tst_rst;

endmodule

// File: rtl/wrst_seq_chk.sv
module wrst_seq_chk #(
    parameter int N_SRC     = 4,
    parameter int N_LCPU    = 3,
    parameter int DRAIN_MAX = 50
) (
    input logic              clk,
    input logic              por_rst,
    input logic [N_SRC-1:0]  warm_req,
    input logic              drain_req,
    input logic              pin_drv_low,
    input logic              host_rst,
    input logic              io_tristate,
    input logic [N_LCPU-1:0] lcpu_rst
);

    localparam logic [7:0] LIM = 8'(DRAIN_MAX);

    logic [7:0] dcnt_q;

    always_ff @(posedge clk) begin
        if (por_rst) begin
            dcnt_q <= '0;
        end else if (drain_req) begin
            if (dcnt_q != 8'hFF) dcnt_q <= dcnt_q + 8'd1;
        end else begin
            dcnt_q <= '0;
        end
    end

    assert_req_start_R2: assert property (@(posedge clk) disable iff (por_rst)
        (|warm_req) |=> (host_rst && io_tristate && drain_req && !pin_drv_low));

    assert_drain_bound_R4: assert property (@(posedge clk) disable iff (por_rst)
        drain_req |-> (dcnt_q < LIM));

    assert_pin_in_reset_R5: assert property (@(posedge clk) disable iff (por_rst)
        pin_drv_low |-> (host_rst && !drain_req));

    assert_release_clean_R6: assert property (@(posedge clk) disable iff (por_rst)
        $fell(host_rst) |-> (!pin_drv_low && !drain_req));

    assert_lcpu_hold_R10: assert property (@(posedge clk) disable iff (por_rst)
        host_rst |=> (&lcpu_rst));

    assert_por_quiet_R11: assert property (@(posedge clk)
        por_rst |=> (!pin_drv_low && !drain_req));

endmodule

bind wrst_seq_top wrst_seq_chk #(
    .N_SRC     (N_SRC),
    .N_LCPU    (N_LCPU),
    .DRAIN_MAX (DRAIN_MAX)
) u_chk (
    .clk         (clk),
    .por_rst     (por_rst),
    .warm_req    (warm_req),
    .drain_req   (drain_req),
    .pin_drv_low (pin_drv_low),
    .host_rst    (host_rst),
    .io_tristate (io_tristate),
    .lcpu_rst    (lcpu_rst)
);

// File: tb/wrst_seq_top_tb_top.sv
`timescale 1ns/1ps
module wrst_seq_top_tb_top;

    localparam int CLK_NS = 20;
    localparam int N_SRC  = 4;
    localparam int N_LCPU = 3;

    logic              clk = 1'b0;
    logic              por_rst = 1'b1;
    logic              tst_rst = 1'b0;
    logic [N_SRC-1:0]  warm_req = '0;
    logic              pin_in;
    logic              pin_drv_low;
    logic              drain_ack = 1'b0;
    logic              drain_req;
    logic [12:0]       rst_time_cfg = '0;
    logic [N_LCPU-1:0] lcpu_rel_wr = '0;
    logic              io_tristate, host_rst, periph_rst, rst_out, dbg_io_oe;
    logic [N_LCPU-1:0] lcpu_rst;
    logic              ext_sw = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // Open-drain pad: low when the block or the outside switch pulls it.
    assign pin_in = ~(pin_drv_low | ext_sw);

    wrst_seq_top dut_i (
        .clk(clk), .por_rst(por_rst), .tst_rst(tst_rst), .warm_req(warm_req),
        .pin_in(pin_in), .pin_drv_low(pin_drv_low), .drain_ack(drain_ack),
        .drain_req(drain_req), .rst_time_cfg(rst_time_cfg), .lcpu_rel_wr(lcpu_rel_wr),
        .io_tristate(io_tristate), .host_rst(host_rst), .periph_rst(periph_rst),
        .lcpu_rst(lcpu_rst), .rst_out(rst_out), .dbg_io_oe(dbg_io_oe)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    len;
        string tag;
    } exp_t;

    exp_t q_drain[$];
    exp_t q_pin[$];
    exp_t q_host[$];

    bit mon_en    = 1'b0;
    int ack_delay = 0;
    int ack_cnt   = 0;
    int run_d = 0, run_p = 0, run_h = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int len, input string tag);
        exp_t e;
        e.len = len;
        e.tag = tag;
        case (kind)
            0: q_drain.push_back(e);
            1: q_pin.push_back(e);
            default: q_host.push_back(e);
        endcase
    endtask

    task automatic pop_cmp(input int kind, input int got);
        exp_t  e;
        bit    have;
        string name;
        have = 1'b0;
        case (kind)
            0: begin name = "drain_req run"; if (q_drain.size() > 0) begin e = q_drain.pop_front(); have = 1'b1; end end
            1: begin name = "pin drive run"; if (q_pin.size() > 0) begin e = q_pin.pop_front(); have = 1'b1; end end
            default: begin name = "host_rst run"; if (q_host.size() > 0) begin e = q_host.pop_front(); have = 1'b1; end end
        endcase
        if (!have) chk(1'b0, "R8", {"unexpected ", name}, got, 0);
        else       chk(got == e.len, e.tag, name, got, e.len);
    endtask

    // Monitor: measures high runs of the sequence outputs and scores them.
    always @(negedge clk) begin
        if (mon_en) begin
            chk(rst_out === host_rst && periph_rst === host_rst && io_tristate === host_rst,
                "R13", "reset outputs agree", {rst_out, periph_rst, io_tristate}, {3{host_rst}});
            if (drain_req) run_d++;
            else if (run_d > 0) begin pop_cmp(0, run_d); run_d = 0; end
            if (pin_drv_low) run_p++;
            else if (run_p > 0) begin pop_cmp(1, run_p); run_p = 0; end
            if (host_rst) run_h++;
            else if (run_h > 0) begin pop_cmp(2, run_h); run_h = 0; end
        end
    end

    // Memory controller model: acknowledges after ack_delay cycles, 0 = never.
    always @(negedge clk) begin
        if (drain_req) begin
            ack_cnt++;
            drain_ack = (ack_delay != 0) && (ack_cnt == ack_delay);
        end else begin
            ack_cnt   = 0;
            drain_ack = 1'b0;
        end
    end

    task automatic at_drive();
        @(posedge clk);
        #5;
    endtask

    task automatic pulse_req(input int idx);
        at_drive(); warm_req[idx] = 1'b1;
        at_drive(); warm_req = '0;
    endtask

    task automatic pulse_rel(input int idx);
        at_drive(); lcpu_rel_wr[idx] = 1'b1;
        at_drive(); lcpu_rel_wr = '0;
    endtask

    task automatic set_times(input int t1, input int t2);
        rst_time_cfg = {t2[4:0], t1[7:0]};
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (host_rst && n < 5000);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_pin();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pin_drv_low && n < 500);
    endtask

    initial begin
        #(CLK_NS * 100000);
        chk(1'b0, "WD", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: power-on reset state
        repeat (4) @(negedge clk);
        chk(host_rst && periph_rst && io_tristate && rst_out, "R1", "resets held in POR", host_rst, 1);
        chk(lcpu_rst == 3'b111, "R1", "local CPU resets in POR", lcpu_rst, 3'b111);
        chk(!pin_drv_low && !drain_req, "R1", "no drive or drain in POR", {pin_drv_low, drain_req}, 0);
        at_drive(); por_rst = 1'b0;
        @(negedge clk);
        chk(!host_rst && !rst_out, "R1", "host released after POR", host_rst, 0);
        chk(lcpu_rst == 3'b111, "R1", "local CPU resets kept after POR", lcpu_rst, 3'b111);
        mon_en = 1'b1;

        // R2 R3 R5 R6: internal request, ack after 3 cycles
        set_times(6, 4); ack_delay = 3;
        push(0, 3, "R3"); push(1, 6, "R5"); push(2, 13, "R6");
        pulse_req(1);
        @(negedge clk);
        chk(host_rst && periph_rst && io_tristate && drain_req && !pin_drv_low, "R2",
            "outputs after request", {host_rst, io_tristate, drain_req, pin_drv_low}, 4'b1110);
        chk(dbg_io_oe == 1'b1, "R12", "debug IO enabled during warm reset", dbg_io_oe, 1);
        wait_idle();
        chk(lcpu_rst == 3'b111, "R10", "local CPUs held after sequence", lcpu_rst, 3'b111);
        pulse_rel(0);
        @(negedge clk);
        chk(lcpu_rst == 3'b110, "R10", "release bit 0", lcpu_rst, 3'b110);

        // R4 R5: drain timeout, zero durations count as one
        set_times(0, 0); ack_delay = 0;
        push(0, 50, "R4"); push(1, 1, "R5"); push(2, 52, "R6");
        pulse_req(2);
        repeat (3) @(negedge clk);
        pulse_rel(1);
        @(negedge clk);
        chk(lcpu_rst == 3'b111, "R10", "release ignored mid-sequence", lcpu_rst, 3'b111);
        wait_idle();
        pulse_rel(2);
        @(negedge clk);
        chk(lcpu_rst == 3'b011, "R10", "release bit 2", lcpu_rst, 3'b011);

        // R5 R6: long durations
        set_times(200, 31); ack_delay = 2;
        push(0, 2, "R3"); push(1, 200, "R5"); push(2, 233, "R6");
        pulse_req(0);
        wait_idle();

        // R7 R8: outside agent pulls the pin
        set_times(6, 4); ack_delay = 3;
        push(1, 30, "R7"); push(0, 3, "R7"); push(2, 37, "R7");
        at_drive(); ext_sw = 1'b1;
        repeat (3) @(negedge clk);
        chk(host_rst == 1'b0, "R7", "no reset before synchronizer delay", host_rst, 0);
        @(negedge clk);
        chk(host_rst && pin_drv_low, "R7", "pin echo starts", {host_rst, pin_drv_low}, 2'b11);
        repeat (8) @(negedge clk);
        at_drive(); ext_sw = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(host_rst == 1'b0, "R8", "no self-triggered sequence", host_rst, 0);

        // R9: restart during pin drive
        ack_delay = 4;
        push(0, 4, "R9"); push(1, 3, "R9"); push(0, 4, "R9"); push(1, 6, "R9"); push(2, 21, "R9");
        pulse_req(3);
        wait_pin();
        @(negedge clk);
        pulse_req(2);
        wait_idle();

        // R11: power-on reset during pin drive
        ack_delay = 5;
        push(0, 5, "R11"); push(1, 3, "R11"); push(2, 9, "R11");
        pulse_req(1);
        wait_pin();
        @(negedge clk);
        at_drive(); por_rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!pin_drv_low && !drain_req && host_rst, "R11", "POR abandons sequence",
            {pin_drv_low, drain_req, host_rst}, 3'b001);
        at_drive(); por_rst = 1'b0;
        @(negedge clk);
        chk(!host_rst && lcpu_rst == 3'b111, "R11", "state after POR", {host_rst, lcpu_rst}, 4'b0111);

        // R12: test reset isolation
        at_drive(); tst_rst = 1'b1;
        @(negedge clk);
        chk(!rst_out && !dbg_io_oe, "R12", "test reset effect", {rst_out, dbg_io_oe}, 0);
        at_drive(); tst_rst = 1'b0;
        @(negedge clk);
        chk(dbg_io_oe == 1'b1, "R12", "debug IO re-enabled", dbg_io_oe, 1);

        repeat (5) @(negedge clk);
        chk(q_drain.size() == 0 && q_pin.size() == 0 && q_host.size() == 0, "R8",
            "all expected runs observed", q_drain.size() + q_pin.size() + q_host.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule